// File: doc/BRIEF.md
# GNSS Serial I/Q Sample Capture

This block sits behind the serial baseband output of a satellite-navigation RF front-end. The front-end sends one bit per rising edge of its sample clock on a single data line. Each complex sample is a four-bit frame made of an I sign bit, an I magnitude bit, a Q sign bit and a Q magnitude bit. A sync pulse marks the first bit of each frame. The block keeps track of the frame position, turns each complete frame into a 4-bit sign/magnitude nibble, and packs two consecutive nibbles into a byte. It writes the bytes into a 2048-byte on-chip buffer.

A capture starts with a single-cycle arm pulse. It fills the buffer from address 0 upwards and stops by itself once the last address has been written. The stored record can then be read out through a simple read port in the same clock domain, for off-line correlation by software. A sticky flag reports any sync pulse that arrives in the middle of a frame.

Top module: `iq_capture_top`

## Requirements
- R1: After reset, `busy`, `done`, `syncErr` and `rdData` are all 0.
- R2: Serial bits that arrive after reset and before the first sync pulse are ignored. The bit sampled together with a sync pulse is frame position 0, and the positions that follow advance by one on each clock.
- R3: Frame bit order on the line is I sign, I magnitude, Q sign, Q magnitude. The nibble built from a frame carries Q sign in bit 3, Q magnitude in bit 2, I sign in bit 1 and I magnitude in bit 0.
- R4: Two consecutive nibbles form one byte. The earlier nibble goes in bits 7:4 and the later one in bits 3:0. Bytes go to consecutive addresses, starting at 0.
- R5: An arm pulse, which may arrive while a capture is running, restarts capture at address 0 and clears `done` and `syncErr`. The first frame captured is the one whose sync bit is sampled together with the arm pulse.
- R6: After the byte at address 2047 is written, `busy` falls and `done` rises on the same clock edge.
- R7: While `done` is set and no arm pulse arrives, serial data leaves the buffer contents unchanged.
- R8: A sync pulse that arrives when the frame position is not 0 sets `syncErr`. It discards both the partial frame and any half-filled byte, and framing restarts from that sync bit.
- R9: A read request (`rdEn` with `rdAddr`) presents the stored byte on `rdData` one clock later. Back-to-back requests return bytes on consecutive clocks, and `rdData` holds its value while `rdEn` is low.
- R10: `syncErr` stays set until the next arm pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Front-end sample clock; all logic runs on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| serData | input | 1 | Serial I/Q bit stream |
| syncIn | input | 1 | Active-high frame-start pulse, aligned with the I sign bit |
| armIn | input | 1 | Single-cycle pulse that starts a new capture |
| rdEn | input | 1 | Read request |
| rdAddr | input | 11 | Buffer address to read |
| rdData | output | 8 | Byte read, valid one clock after the request |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Buffer full, capture ended |
| syncErr | output | 1 | Sticky flag for a sync pulse seen mid-frame |

## Verification
The hardest case to reach is a sync pulse that arrives in the middle of a frame while a byte is half built. The stimulus has to complete one frame, send a sync plus one more bit, and then start a fresh synced frame at once. The read-back then shows that the orphaned nibble never reached the buffer. The stop at a full buffer needs all 4096 frames to be streamed, with the status checked once just before and once just after the final commit. A bench-side frame-position tracker inserts idle bits so that every deliberate sync lands at position 0.

// File: rtl/iq_capture_pkg.sv
package iq_capture_pkg;

  // Bits per serial frame: I sign, I magnitude, Q sign, Q magnitude.
  localparam int FRAME_LEN = 4;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam int NIB_W     = 4;
  localparam int BYTE_W    = 2 * NIB_W;

  // Strobes sent from the control to the datapath each clock.
  typedef struct packed {
    logic             takeBit;    // current serial bit belongs to a frame
    logic [POS_W-1:0] bitSel;     // frame position of the current bit
    logic             pushNibble; // frame complete, first half of a byte
    logic             commitByte; // frame complete, second half: write byte
  } capStrobe_t;

endpackage

// File: rtl/iq_capture_ctrl.sv
module iq_capture_ctrl
  import iq_capture_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic              armIn,
  output capStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              busy,
  output logic              done,
  output logic              syncErr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] bitPos;   // position of the bit expected this clock
  logic             framed;   // a sync has been seen since reset
  logic             halfFull; // upper nibble of the byte is pending

  logic [POS_W-1:0] posNow;
  logic             active;
  logic             frameEnd;
  logic             badSync;
  logic             captureOk;

  always_comb begin
    posNow    = syncIn ? '0 : bitPos;
    active    = syncIn || framed;
    frameEnd  = active && (posNow == LAST_POS);
    badSync   = syncIn && framed && (bitPos != '0);
    captureOk = busy && !armIn && frameEnd;

    strobe.takeBit    = active;
    strobe.bitSel     = posNow;
    strobe.pushNibble = captureOk && !halfFull;
    strobe.commitByte = captureOk && halfFull;
  end

  // Framing tracker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos <= '0;
      framed <= 1'b0;
    end else if (active) begin
      framed <= 1'b1;
      bitPos <= posNow + 1'b1;
    end
  end

  // Capture sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      syncErr  <= 1'b0;
      halfFull <= 1'b0;
      wrAddr   <= '0;
    end else if (armIn) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      syncErr  <= 1'b0;
      halfFull <= 1'b0;
      wrAddr   <= '0;
    end else begin
      if (badSync) begin
        syncErr  <= 1'b1;
        halfFull <= 1'b0;
      end
      if (strobe.pushNibble) begin
        halfFull <= 1'b1;
      end
      if (strobe.commitByte) begin
        halfFull <= 1'b0;
        wrAddr   <= wrAddr + 1'b1;
        if (wrAddr == LAST_ADDR) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2: without a sync the frame position advances by one per clock
  a_r2_pos_advance: assert property (@(posedge clk) disable iff (!rstN)
    framed && !syncIn |=> bitPos == $past(bitPos) + 1'b1);

  // R4: each committed byte below the top moves the write address up by one
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitByte && (wrAddr != LAST_ADDR) |=> wrAddr == $past(wrAddr) + 1'b1);

  // R6: running and finished are never reported together
  a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R6: the last commit ends the capture
  a_r6_stop_at_full: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitByte && (wrAddr == LAST_ADDR) |=> done && !busy);

  // R8: a mid-frame sync raises the error flag
  a_r8_sync_err: assert property (@(posedge clk) disable iff (!rstN)
    syncIn && framed && (bitPos != '0) && !armIn |=> syncErr);

  // R10: the error flag holds until an arm pulse
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    syncErr && !armIn |=> syncErr);

endmodule

// File: rtl/iq_capture_datapath.sv
module iq_capture_datapath
  import iq_capture_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serData,
  input  capStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  // Held frame bits: [0] I sign, [1] I magnitude, [2] Q sign
  logic [FRAME_LEN-2:0] frameHold;
  logic [NIB_W-1:0]     upperNib;
  logic [NIB_W-1:0]     nibble;
  logic [BYTE_W-1:0]    store [DEPTH];

  // The Q magnitude bit is taken straight from the line on the last position.
  assign nibble = {frameHold[2], serData, frameHold[0], frameHold[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameHold <= '0;
      upperNib  <= '0;
    end else begin
      if (strobe.takeBit && (strobe.bitSel != LAST_POS)) begin
        frameHold[strobe.bitSel] <= serData;
      end
      if (strobe.pushNibble) begin
        upperNib <= nibble;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commitByte) begin
      store[wrAddr] <= {upperNib, nibble};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      rdData <= store[rdAddr];
    end
  end

  // R4: a frame completes either the upper or the lower half, never both
  a_r4_one_half: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.pushNibble, strobe.commitByte}));

  // R3: nibbles are only formed on the Q magnitude position of a tracked frame
  a_r3_end_of_frame: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushNibble || strobe.commitByte) |-> strobe.takeBit && (strobe.bitSel == LAST_POS));

endmodule

// File: rtl/iq_capture_top.sv
module iq_capture_top
  import iq_capture_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serData,
  input  logic              syncIn,
  input  logic              armIn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              done,
  output logic              syncErr
);

  capStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr;

  iq_capture_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .syncIn  (syncIn),
    .armIn   (armIn),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .busy    (busy),
    .done    (done),
    .syncErr (syncErr)
  );

  iq_capture_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .serData (serData),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .rdEn    (rdEn),
    .rdAddr  (rdAddr),
    .rdData  (rdData)
  );

endmodule

// File: tb/sim_iq_capture_top.sv
module sim_iq_capture_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 11;
  localparam int DEPTH      = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              serData = 1'b0;
  logic              syncIn = 1'b0;
  logic              armIn = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0]        rdData;
  logic              busy, done, syncErr;

  int checks = 0;
  int failures = 0;
  logic [1:0] bPhase = 2'd0;   // bench model of frame position
  logic [7:0] expMem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_capture_top #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .serData(serData), .syncIn(syncIn), .armIn(armIn),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .busy(busy), .done(done), .syncErr(syncErr)
  );

  // Frame position of the bit driven at the next negedge (R2 framing rule)
  always @(posedge clk) begin
    if (!rstN) bPhase <= 2'd0;
    else if (syncIn) bPhase <= 2'd1;
    else bPhase <= bPhase + 2'd1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Frame bits given as {si, mi, sq, mq}; nibble is {sq, mq, si, mi} (R3)
  function automatic logic [3:0] nibOf(input logic [3:0] f);
    return {f[1], f[0], f[3], f[2]};
  endfunction

  function automatic logic [3:0] patFrame(input int k);
    logic [15:0] v;
    v = 16'(k);
    return v[3:0] ^ v[7:4] ^ v[11:8];
  endfunction

  task automatic sendBit(input logic b, input logic s, input logic a);
    @(negedge clk);
    serData = b; syncIn = s; armIn = a;
  endtask

  task automatic goIdle();
    @(negedge clk);
    serData = 1'b0; syncIn = 1'b0; armIn = 1'b0;
  endtask

  task automatic sendFrame(input logic [3:0] f, input bit align, input logic arm);
    @(negedge clk);
    if (align) begin
      while (bPhase != 2'd0) begin
        serData = 1'b0; syncIn = 1'b0; armIn = 1'b0;
        @(negedge clk);
      end
    end
    serData = f[3]; syncIn = 1'b1; armIn = arm;
    sendBit(f[2], 1'b0, 1'b0);
    sendBit(f[1], 1'b0, 1'b0);
    sendBit(f[0], 1'b0, 1'b0);
  endtask

  task automatic readByte(input int addr, input logic [7:0] exp, input string req);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = ADDR_W'(addr);
    @(negedge clk);
    rdEn = 1'b0;
    chk(rdData == exp, req, rdData, exp);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(syncErr == 1'b0, "R1 syncErr", syncErr, 0);
    chk(rdData == 8'h00, "R1 rdData", rdData, 0);
  endtask

  // Unsynced garbage first, then four synced frames with known encodings
  task automatic testEncoding();
    sendBit(1'b1, 1'b0, 1'b1);
    sendBit(1'b1, 1'b0, 1'b0);
    sendBit(1'b0, 1'b0, 1'b0);
    sendBit(1'b1, 1'b0, 1'b0);
    sendBit(1'b1, 1'b0, 1'b0);
    sendBit(1'b1, 1'b0, 1'b0);
    sendFrame(4'b1001, 1'b0, 1'b0);  // nibble 6
    sendFrame(4'b0110, 1'b0, 1'b0);  // nibble 9
    sendFrame(4'b1100, 1'b0, 1'b0);  // nibble 3
    sendFrame(4'b0011, 1'b0, 1'b0);  // nibble C
    goIdle();
    chk(busy == 1'b1, "R5 busy after arm", busy, 1);
    chk(syncErr == 1'b0, "R8 aligned stream no error", syncErr, 0);
    readByte(0, 8'h69, "R2 R3 R4 byte0");
    readByte(1, 8'h3C, "R3 R4 byte1");
  endtask

  // Mid-frame sync with a half-built byte pending
  task automatic testSyncError();
    sendFrame(4'b1111, 1'b1, 1'b1);  // re-arm; nibble F becomes the pending half
    sendBit(1'b1, 1'b1, 1'b0);       // partial frame: sync + one bit
    sendBit(1'b1, 1'b0, 1'b0);
    sendFrame(4'b1010, 1'b0, 1'b0);  // sync at position 2, nibble A
    sendFrame(4'b0101, 1'b0, 1'b0);  // nibble 5
    goIdle();
    chk(syncErr == 1'b1, "R8 flag set", syncErr, 1);
    readByte(0, 8'hA5, "R8 half byte discarded");
    sendFrame(4'b0000, 1'b1, 1'b0);
    sendFrame(4'b0000, 1'b1, 1'b0);
    goIdle();
    chk(syncErr == 1'b1, "R10 flag sticky", syncErr, 1);
    sendFrame(4'b0000, 1'b1, 1'b1);
    goIdle();
    chk(syncErr == 1'b0, "R5 arm clears flag", syncErr, 0);
  endtask

  task automatic testFill();
    for (int a = 0; a < DEPTH; a++)
      expMem[a] = {nibOf(patFrame(2*a)), nibOf(patFrame(2*a+1))};
    sendFrame(patFrame(0), 1'b1, 1'b1);
    for (int k = 1; k < 2*DEPTH - 1; k++) sendFrame(patFrame(k), 1'b0, 1'b0);
    chk(busy == 1'b1, "R6 busy before last byte", busy, 1);
    chk(done == 1'b0, "R6 done before last byte", done, 0);
    sendFrame(patFrame(2*DEPTH - 1), 1'b0, 1'b0);
    goIdle();
    chk(busy == 1'b0, "R6 busy after last byte", busy, 0);
    chk(done == 1'b1, "R6 done after last byte", done, 1);
    readByte(0, expMem[0], "R4 fill first");
    readByte(DEPTH - 1, expMem[DEPTH - 1], "R6 fill last");
  endtask

  task automatic testIgnoreAfterDone();
    for (int k = 0; k < 20; k++) sendFrame(4'b1111, 1'b1, 1'b0);
    goIdle();
    chk(done == 1'b1, "R7 done held", done, 1);
    for (int a = 0; a < DEPTH; a++) readByte(a, expMem[a], "R7 contents unchanged");
  endtask

  task automatic testReadTiming();
    @(negedge clk);
    rdEn = 1'b1; rdAddr = ADDR_W'(5);
    @(negedge clk);
    rdAddr = ADDR_W'(6);
    chk(rdData == expMem[5], "R9 first of pair", rdData, expMem[5]);
    @(negedge clk);
    rdEn = 1'b0; rdAddr = ADDR_W'(9);
    chk(rdData == expMem[6], "R9 second of pair", rdData, expMem[6]);
    @(negedge clk);
    chk(rdData == expMem[6], "R9 hold without request", rdData, expMem[6]);
  endtask

  initial begin
    fork
      begin
        testReset();
        testEncoding();
        testSyncError();
        testFill();
        testIgnoreAfterDone();
        testReadTiming();
      end
      begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule